// File: doc/BRIEF.md
# Duplicated Control-Flow Checker

This block catches faults in control flow, as opposed to faults in data, by doing each control decision twice and comparing the two copies. The checker covers two kinds of control flow: branches and loops.

For a branch, the host logic opens a check window and presents the branch condition. Inside the window, the primary branch path pulses one marker and an independent second evaluation of the same condition pulses another. When the window closes, the checker compares the captured condition with both markers. If the three do not all agree, it raises a branch error.

For a loop, the checker keeps two counters. One advances with the real datapath's iteration strobe. The other advances with a strobe from a dummy path that runs the same trip count. At loop exit the two counts are compared, and any difference raises a loop error.

Both error outputs are sticky until they are cleared. Each completed check also produces a one-cycle strobe. A fault-injection input can swallow a dummy-path step, so that a mismatch can be forced on purpose.

Top module: `cf_dup_checker`

## Requirements
- R1: During and right after reset, `br_err`, `lp_err`, `br_chk` and `lp_chk` are all 0.
- R2: `br_begin` captures `br_cond` and clears both branch markers. Markers left over from an earlier branch have no effect on the next check. A marker pulsed in the same cycle as `br_begin` is also discarded.
- R3: `br_mark_a` sets marker A and `br_mark_b` sets marker B. A marker pulsed in the same cycle as `br_end` still counts toward that check.
- R4: On `br_end`, `br_chk` is 1 in the cycle after. In that same cycle `br_err` becomes 1 if the captured condition, marker A and marker B are not all equal. When all three are 0 or all three are 1, `br_err` keeps its value.
- R5: A `br_end` in the same cycle as `br_begin` is ignored. No `br_chk` pulse follows it and `br_err` does not change.
- R6: `lp_start` clears both loop counters to 0. Any step strobes in the same cycle are discarded, and an `lp_done` in that cycle is ignored (no `lp_chk`).
- R7: `lp_step_d` advances the datapath counter by 1 and `lp_step_m` advances the dummy counter by 1. The counters are CNT_W bits wide (16 by default) and wrap modulo 2^CNT_W.
- R8: On `lp_done`, `lp_chk` is 1 in the cycle after. The two counts are compared including any steps in the `lp_done` cycle. A difference sets `lp_err`, and equal counts leave `lp_err` unchanged.
- R9: When `inj_drop` is high in a cycle where `lp_step_m` is high, that dummy step is not counted. `inj_drop` has no effect on the datapath counter.
- R10: `br_err` and `lp_err` hold at 1 until `clr_err` is pulsed. If a failing check lands in the same cycle as `clr_err`, the error is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_err | input | 1 | Clears both sticky errors |
| br_begin | input | 1 | Opens a branch check window and captures the condition |
| br_cond | input | 1 | Branch condition, sampled on `br_begin` |
| br_mark_a | input | 1 | Primary evaluation took the branch |
| br_mark_b | input | 1 | Independent evaluation took the branch |
| br_end | input | 1 | Closes the branch window and requests the comparison |
| lp_start | input | 1 | Loop entry, clears both counters |
| lp_step_d | input | 1 | One iteration on the real datapath |
| lp_step_m | input | 1 | One iteration on the dummy path |
| inj_drop | input | 1 | Swallows a coincident dummy step (fault injection) |
| lp_done | input | 1 | Loop exit, requests the count comparison |
| br_chk | output | 1 | One-cycle strobe: a branch check completed |
| br_err | output | 1 | Sticky branch mismatch |
| lp_chk | output | 1 | One-cycle strobe: a loop check completed |
| lp_err | output | 1 | Sticky loop count mismatch |

## Verification
A wrong branch marker or a miscaptured condition stays hidden until `br_end`. It then shows one cycle later as a wrong `br_err` beside the `br_chk` strobe. A corrupted loop counter gives no sign for the whole loop and surfaces only at `lp_done`, as a wrong `lp_err` one cycle later.

The bench therefore closes every branch and loop it opens and samples both errors at the strobe. It drives every combination of condition and markers, and it also runs the counter wrap, the same-cycle overrides and the clear-versus-set collision, where a miscounted or stale state would otherwise pass unseen.

// File: rtl/cf_dup_checker.sv
module cf_dup_checker #(
  parameter int CNT_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_err,
  input  logic br_begin,
  input  logic br_cond,
  input  logic br_mark_a,
  input  logic br_mark_b,
  input  logic br_end,
  input  logic lp_start,
  input  logic lp_step_d,
  input  logic lp_step_m,
  input  logic inj_drop,
  input  logic lp_done,
  output logic br_chk,
  output logic br_err,
  output logic lp_chk,
  output logic lp_err
);

  logic cond_q, fa_q, fb_q;
  logic [CNT_W-1:0] cnt_d, cnt_m;

  wire fa_n   = fa_q | br_mark_a;
  wire fb_n   = fb_q | br_mark_b;
  wire br_hit = br_end & ~br_begin;
  wire br_bad = (cond_q ^ fa_n) | (cond_q ^ fb_n);

  wire                 step_m_eff = lp_step_m & ~inj_drop;
  wire [CNT_W-1:0]     cd_n       = cnt_d + CNT_W'(lp_step_d);
  wire [CNT_W-1:0]     cm_n       = cnt_m + CNT_W'(step_m_eff);
  wire                 lp_hit     = lp_done & ~lp_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_q <= 1'b0;
      fa_q   <= 1'b0;
      fb_q   <= 1'b0;
    end else if (br_begin) begin
      cond_q <= br_cond;
      fa_q   <= 1'b0;
      fb_q   <= 1'b0;
    end else begin
      fa_q <= fa_n;
      fb_q <= fb_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_d <= '0;
      cnt_m <= '0;
    end else if (lp_start) begin
      cnt_d <= '0;
      cnt_m <= '0;
    end else begin
      cnt_d <= cd_n;
      cnt_m <= cm_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      br_chk <= 1'b0;
      br_err <= 1'b0;
      lp_chk <= 1'b0;
      lp_err <= 1'b0;
    end else begin
      br_chk <= br_hit;
      br_err <= (br_err & ~clr_err) | (br_hit & br_bad);
      lp_chk <= lp_hit;
      lp_err <= (lp_err & ~clr_err) | (lp_hit & (cd_n != cm_n));
    end
  end

  AST_BR_ERR_WITH_CHK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(br_err) |-> br_chk);  // R4
  AST_LP_ERR_WITH_CHK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lp_err) |-> lp_chk);  // R8
  AST_BR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (br_err && !clr_err) |=> br_err);  // R10
  AST_LP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_err && !clr_err) |=> lp_err);  // R10
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    lp_start |=> (cnt_d == '0 && cnt_m == '0));  // R6
  AST_INJ_HOLDS_DUMMY: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_drop && !lp_start) |=> $stable(cnt_m));  // R9
  AST_SAME_CYCLE_END: assert property (@(posedge clk) disable iff (!rst_n)
    (br_begin && br_end) |=> !br_chk);  // R5

endmodule

// File: tb/cf_dup_checker_tb.sv
module cf_dup_checker_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic clr_err = 0, br_begin = 0, br_cond = 0, br_mark_a = 0, br_mark_b = 0, br_end = 0;
  logic lp_start = 0, lp_step_d = 0, lp_step_m = 0, inj_drop = 0, lp_done = 0;
  logic br_chk, br_err, lp_chk, lp_err;
  int checks = 0, fails = 0;

  // {cond, mark_a, mark_b, expected br_err}
  localparam logic [3:0] VEC [8] = '{
    4'b0000, 4'b0011, 4'b0101, 4'b0111,
    4'b1001, 4'b1011, 4'b1101, 4'b1110
  };

  always #(CLK_PERIOD/2) clk = ~clk;

  cf_dup_checker #(.CNT_W(16)) dut_i (
    .clk, .rst_n, .clr_err, .br_begin, .br_cond, .br_mark_a, .br_mark_b, .br_end,
    .lp_start, .lp_step_d, .lp_step_m, .inj_drop, .lp_done,
    .br_chk, .br_err, .lp_chk, .lp_err
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic idle;
    {clr_err, br_begin, br_cond, br_mark_a, br_mark_b, br_end} = '0;
    {lp_start, lp_step_d, lp_step_m, inj_drop, lp_done} = '0;
  endtask

  task automatic clear;
    clr_err = 1; tick; clr_err = 0;
  endtask

  task automatic branch(input logic c, input logic a, input logic b);
    br_begin = 1; br_cond = c; tick; br_begin = 0;
    br_mark_a = a; tick; br_mark_a = 0;
    br_mark_b = b; tick; br_mark_b = 0;
    br_end = 1; tick; br_end = 0;
  endtask

  task automatic loop_run(input int nd, input int nm, input int ndrop);
    lp_start = 1; tick; lp_start = 0;
    for (int i = 0; i < nd; i++) begin lp_step_d = 1; tick; end
    lp_step_d = 0;
    for (int i = 0; i < nm; i++) begin lp_step_m = 1; inj_drop = (i < ndrop); tick; end
    lp_step_m = 0; inj_drop = 0;
    lp_done = 1; tick; lp_done = 0;
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    tick;
    chk("R1 br_err in reset", br_err, 0);
    chk("R1 lp_err in reset", lp_err, 0);
    rst_n = 1; tick;
    chk("R1 br_chk after reset", br_chk, 0);
    chk("R1 lp_chk after reset", lp_chk, 0);

    // R4 R3: every combination of condition and markers
    for (int v = 0; v < 8; v++) begin
      clear;
      branch(VEC[v][3], VEC[v][2], VEC[v][1]);
      chk($sformatf("R4 strobe vec %0d", v), br_chk, 1);
      chk($sformatf("R4 err vec %0d", v), br_err, VEC[v][0]);
      tick;
      chk($sformatf("R4 strobe one cycle vec %0d", v), br_chk, 0);
    end

    // R2: stale markers from before br_begin are discarded
    clear;
    br_mark_a = 1; br_mark_b = 1; tick; idle;
    branch(0, 0, 0);
    chk("R2 stale markers ignored", br_err, 0);
    // R2: marker in begin cycle discarded
    br_begin = 1; br_cond = 1; br_mark_a = 1; br_mark_b = 1; tick; idle;
    br_mark_b = 1; tick; idle;
    br_end = 1; tick; idle;
    chk("R2 marker in begin cycle dropped", br_err, 1);

    // R3: markers in the br_end cycle count
    clear;
    br_begin = 1; br_cond = 1; tick; idle;
    br_end = 1; br_mark_a = 1; br_mark_b = 1; tick; idle;
    chk("R3 end-cycle markers counted", br_err, 0);

    // R5: end together with begin ignored
    clear;
    br_begin = 1; br_cond = 1; br_end = 1; tick; idle;
    chk("R5 no strobe", br_chk, 0);
    chk("R5 no error", br_err, 0);

    // R10: sticky and clear/set collision
    clear;
    branch(1, 0, 1);
    tick; tick;
    chk("R10 br_err sticky", br_err, 1);
    branch(1, 1, 1);
    chk("R10 passing check keeps br_err", br_err, 1);
    clear;
    chk("R10 clr_err clears br_err", br_err, 0);
    br_begin = 1; br_cond = 0; tick; idle;
    br_mark_a = 1; tick; idle;
    br_end = 1; clr_err = 1; tick; idle;
    chk("R10 set wins over clear", br_err, 1);
    clear;

    // R8 R7: equal loop
    loop_run(5, 5, 0);
    chk("R8 lp_chk strobe", lp_chk, 1);
    chk("R8 equal counts no error", lp_err, 0);
    tick;
    chk("R8 strobe one cycle", lp_chk, 0);
    loop_run(4, 5, 0);
    chk("R8 unequal counts error", lp_err, 1);
    tick;
    chk("R10 lp_err sticky", lp_err, 1);
    clear;
    chk("R10 clr_err clears lp_err", lp_err, 0);

    // R9: injected drop
    loop_run(6, 6, 1);
    chk("R9 drop forces mismatch", lp_err, 1);
    clear;
    loop_run(6, 7, 1);
    chk("R9 drop only hits dummy", lp_err, 0);

    // R8: steps in done cycle counted
    lp_start = 1; tick; idle;
    lp_step_d = 1; lp_step_m = 1; lp_done = 1; tick; idle;
    chk("R8 done-cycle steps equal", lp_err, 0);
    lp_start = 1; tick; idle;
    lp_step_d = 1; lp_done = 1; tick; idle;
    chk("R8 done-cycle step counted", lp_err, 1);
    clear;

    // R6: start overrides steps and done
    lp_start = 1; lp_step_d = 1; tick; idle;
    lp_done = 1; tick; idle;
    chk("R6 start drops step", lp_err, 0);
    lp_step_d = 1; tick; idle;
    lp_start = 1; lp_done = 1; tick; idle;
    chk("R6 done in start cycle ignored", lp_chk, 0);
    lp_done = 1; tick; idle;
    chk("R6 start cleared counters", lp_err, 0);

    // R7: 16-bit wrap, 65536 datapath steps equals 0 dummy steps
    loop_run(65536, 0, 0);
    chk("R7 counter wraps", lp_err, 0);
    chk("R7 wrap strobe", lp_chk, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule